// File: doc/BRIEF.md
# I2C Byte-Memory Slave with Write Guard

This block is the serial front end of a small on-chip byte store. It watches the SCL and SDA lines of an I2C bus and recognises bus conditions: start, repeated start and stop. It answers one 7-bit device address. When it needs to signal, it pulls SDA low through an open-drain enable. The store itself is a register array with a synchronous read port, so block RAM can be inferred for it.

A master writes in this order: the device address with the write bit, then a word address, then any number of data bytes. The word address sets an internal pointer, and each data byte lands at the pointer, which then advances. To read, the master sends the device address with the read bit. The slave then streams bytes from the pointer until the master declines one. A repeated start between the two lets the master set the pointer and then read from it.

An active-high guard input refuses writes. A parameter chooses whether it guards the whole array or only the half whose top address bit is set. Refused bytes are still acknowledged.

Top module: `i2c_mem_slave`

## Requirements
- R1: With SCL high, an SDA fall is a start. It aborts any byte in progress and restarts device-address reception. A repeated start inside a transaction behaves the same way and keeps the word pointer.
- R2: The block only ever asserts `sda_oe`, meaning pull SDA low, or releases it. `sda_oe` changes only while SCL is low, and it is released after reset.
- R3: The first byte after a start is the device address, MSB first, followed by the R/W bit (0 = write, 1 = read). If the 7 address bits equal {DEV_PREFIX (default 4'b1010), dev_sel[2:0]}, the slave pulls SDA low in the 9th clock (ACK).
- R4: On an address mismatch the slave gives no ACK, and it drives nothing and stores nothing until the next start.
- R5: In a write, the first byte after the device address loads the word pointer from its low AW bits (AW = 5 by default). Every later byte is ACKed and stored at the pointer. The pointer then increments and wraps from 2^AW-1 to 0.
- R6: In a read, the slave sends the byte at the pointer MSB first and then increments the pointer, with the same wrap. It carries on as long as the master ACKs.
- R7: If the master NACKs a read byte (SDA high in the 9th clock), the slave releases SDA. Further clocks read 0xFF until a stop or a start.
- R8: A stop (SDA rise with SCL high) returns the slave to idle, and bytes clocked in after it without a start get no ACK.
- R9: With WP_FULL = 0 and `wp` = 1, data bytes aimed at addresses with the top address bit set are ACKed but not stored. The lower half is still written.
- R10: With WP_FULL = 1 and `wp` = 1, every data byte is ACKed and none is stored.
- R11: With `wp` = 0, writes to any address are stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| dev_sel | input | 3 | Low three bits of the device address |
| wp | input | 1 | Write guard, active high |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
On every cycle, the assertions check four things: the SDA enable stays steady across SCL-high periods, the slave keeps silent once it has dropped out of a transaction, an acknowledge is raised only for a matching device address, and the bit counter stays in range. Other behaviour depends on what reaches the array, and only the bench's bus-level scenarios can show it. This covers stored contents, pointer wrap, sequential read order, the effect of each guard mode, and that a dropped or stopped slave accepts nothing. The bench reads these back through ordinary I2C reads with an open-drain bus model.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WRITE,
    ST_READ,
    ST_WAIT
  } phase_t;
endpackage

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA moving while SCL stays high is never data
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_ram.sv
module i2c_byte_ram #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R5: a store never targets an undefined location
  a_r5_write_addr_known: assert property (@(posedge clk) we |-> !$isunknown(waddr));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [3:0] DEV_PREFIX  = 4'b1010,
  parameter int         AW          = 5,
  parameter bit         WP_FULL     = 1'b0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel,
  input  logic       wp,
  output logic       sda_oe
);
  localparam int DW = 8;
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] END_SLOT = 4'd9;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_cond_detect #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  phase_t        phase;
  logic [3:0]    cnt;
  logic [DW-1:0] rx, tx;
  logic          rw, mnack;
  logic [AW-1:0] ptr;
  logic [DW-1:0] rdata;
  logic          guarded, wr_en;

  assign guarded = wp & (WP_FULL | ptr[AW-1]);
  assign wr_en   = scl_fall & (cnt == ACK_SLOT) & (phase == ST_WRITE) & ~guarded;

  i2c_byte_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(ptr), .wdata(rx),
    .raddr(ptr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= ST_IDLE;
      cnt    <= '0;
      rx     <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      mnack  <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      phase  <= ST_DEV;
      cnt    <= '0;
      mnack  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      phase  <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (phase != ST_IDLE && phase != ST_WAIT) begin
      if (scl_rise) begin
        if (cnt < ACK_SLOT) rx <= {rx[DW-2:0], sda_s};
        else                mnack <= sda_s;
        cnt <= cnt + 4'd1;
      end
      if (scl_fall) begin
        case (cnt)
          ACK_SLOT: begin
            case (phase)
              ST_DEV: begin
                if (rx[7:1] == {DEV_PREFIX, dev_sel}) begin
                  sda_oe <= 1'b1;
                  rw     <= rx[0];
                end else begin
                  phase  <= ST_WAIT;
                  sda_oe <= 1'b0;
                end
              end
              ST_WORD: begin
                ptr    <= rx[AW-1:0];
                sda_oe <= 1'b1;
              end
              ST_WRITE: begin
                ptr    <= ptr + 1'b1;
                sda_oe <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end
          END_SLOT: begin
            cnt <= '0;
            case (phase)
              ST_DEV: begin
                if (rw) begin
                  phase  <= ST_READ;
                  tx     <= rdata;
                  sda_oe <= ~rdata[7];
                  ptr    <= ptr + 1'b1;
                end else begin
                  phase  <= ST_WORD;
                  sda_oe <= 1'b0;
                end
              end
              ST_WORD: begin
                phase  <= ST_WRITE;
                sda_oe <= 1'b0;
              end
              ST_READ: begin
                if (mnack) begin
                  phase  <= ST_WAIT;
                  sda_oe <= 1'b0;
                end else begin
                  tx     <= rdata;
                  sda_oe <= ~rdata[7];
                  ptr    <= ptr + 1'b1;
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end
          default: begin
            if (phase == ST_READ) sda_oe <= ~tx[3'd7 - cnt[2:0]];
          end
        endcase
      end
    end
  end

  // R2: SDA drive stays steady through every SCL-high interval
  a_r2_oe_steady_scl_high: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

  // R4: once dropped out, the slave keeps the line released
  a_r4_silent_when_dropped: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_WAIT) |-> !sda_oe);

  // R3: the address acknowledge follows only a matching device address
  a_r3_ack_needs_match: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && $past(phase) == ST_DEV) |-> ($past(rx[7:1]) == {DEV_PREFIX, dev_sel}));

  // R1: bit counter never passes the slot after the acknowledge
  a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (rst) cnt <= END_SLOT);
endmodule

// File: tb/sim_i2c_mem_slave.sv
module sim_i2c_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 10;
  localparam logic [6:0] DEV0 = 7'b1010010;
  localparam logic [6:0] DEV1 = 7'b1010101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp0 = 1'b0;
  logic wp1 = 1'b0;
  logic oe0, oe1;
  logic sda_bus;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain bus with pull-up
  assign sda_bus = m_sda & ~oe0 & ~oe1;

  i2c_mem_slave #(.WP_FULL(1'b0)) u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
    .dev_sel(3'b010), .wp(wp0), .sda_oe(oe0)
  );

  i2c_mem_slave #(.WP_FULL(1'b1)) u1 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
    .dev_sel(3'b101), .wp(wp1), .sda_oe(oe1)
  );

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_start();
    m_sda = 1'b1; q();
    m_scl = 1'b1; q();
    m_sda = 1'b0; q();
    m_scl = 1'b0; q();
  endtask

  task automatic send_stop();
    m_sda = 1'b0; q();
    m_scl = 1'b1; q();
    m_sda = 1'b1; q(); q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q();
      m_scl = 1'b1; q(); q();
      m_scl = 1'b0; q();
    end
    m_sda = 1'b1; q();
    m_scl = 1'b1; q();
    ack_n = sda_bus; q();
    m_scl = 1'b0; q();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; q();
      m_scl = 1'b1; q();
      b[i] = sda_bus; q();
      m_scl = 1'b0; q();
    end
    m_sda = nack; q();
    m_scl = 1'b1; q(); q();
    m_scl = 1'b0; q();
  endtask

  task automatic wr_seq(input logic [6:0] dev, input logic [7:0] wa, input int n,
                        input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                        input string req);
    logic a;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    send_start();
    send_byte({dev, 1'b0}, a); chk("R3 dev ack", {7'd0, a}, 8'd0);
    send_byte(wa, a);          chk(req, {7'd0, a}, 8'd0);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a);      chk(req, {7'd0, a}, 8'd0);
    end
    send_stop();
  endtask

  task automatic rd_seq(input logic [6:0] dev, input logic [7:0] wa, input int n,
                        input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2,
                        input string req);
    logic a;
    logic [7:0] b;
    logic [7:0] e [3];
    e[0] = e0; e[1] = e1; e[2] = e2;
    send_start();
    send_byte({dev, 1'b0}, a); chk("R3 dev ack", {7'd0, a}, 8'd0);
    send_byte(wa, a);          chk("R5 word ack", {7'd0, a}, 8'd0);
    send_start();
    send_byte({dev, 1'b1}, a); chk("R1 repeated start ack", {7'd0, a}, 8'd0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      chk(req, b, e[i]);
    end
    send_stop();
  endtask

  task automatic t_reset();
    chk("R2 reset released", {7'd0, sda_bus}, 8'd1);
    chk("R2 reset oe", {6'd0, oe1, oe0}, 8'd0);
  endtask

  task automatic t_write_read();
    wr_seq(DEV0, 8'd3, 3, 8'hA1, 8'hB2, 8'hC3, "R5 write ack");
    rd_seq(DEV0, 8'd3, 3, 8'hA1, 8'hB2, 8'hC3, "R6 seq read");
  endtask

  task automatic t_wrap();
    wr_seq(DEV0, 8'd31, 2, 8'h11, 8'h22, 8'h00, "R5 wrap write");
    rd_seq(DEV0, 8'd31, 2, 8'h11, 8'h22, 8'h00, "R6 wrap read");
  endtask

  task automatic t_mismatch();
    logic a;
    send_start();
    send_byte({7'b1010111, 1'b0}, a); chk("R4 low bits mismatch", {7'd0, a}, 8'd1);
    send_byte(8'h03, a);              chk("R4 ignored byte", {7'd0, a}, 8'd1);
    send_byte(8'h55, a);              chk("R4 ignored data", {7'd0, a}, 8'd1);
    send_stop();
    send_start();
    send_byte({7'b0110010, 1'b0}, a); chk("R4 prefix mismatch", {7'd0, a}, 8'd1);
    send_stop();
    rd_seq(DEV0, 8'd3, 1, 8'hA1, 8'h00, 8'h00, "R4 memory untouched");
  endtask

  task automatic t_nack_release();
    logic a;
    logic [7:0] b;
    send_start();
    send_byte({DEV0, 1'b0}, a); chk("R3 dev ack", {7'd0, a}, 8'd0);
    send_byte(8'd0, a);         chk("R5 word ack", {7'd0, a}, 8'd0);
    send_start();
    send_byte({DEV0, 1'b1}, a); chk("R1 repeated start ack", {7'd0, a}, 8'd0);
    recv_byte(1'b1, b);         chk("R6 read addr0", b, 8'h22);
    recv_byte(1'b1, b);         chk("R7 released after nack", b, 8'hFF);
    send_stop();
  endtask

  task automatic t_after_stop();
    logic a;
    send_byte({DEV0, 1'b0}, a); chk("R8 no ack after stop", {7'd0, a}, 8'd1);
    send_byte(8'h00, a);        chk("R8 still idle", {7'd0, a}, 8'd1);
    send_stop();
  endtask

  task automatic t_wp_half();
    wr_seq(DEV0, 8'd16, 1, 8'h77, 8'h00, 8'h00, "R11 write upper");
    wp0 = 1'b1;
    wr_seq(DEV0, 8'd14, 3, 8'h5A, 8'h5B, 8'h5C, "R9 guarded ack");
    rd_seq(DEV0, 8'd14, 3, 8'h5A, 8'h5B, 8'h77, "R9 half guard");
    wp0 = 1'b0;
    wr_seq(DEV0, 8'd16, 1, 8'h88, 8'h00, 8'h00, "R11 write ack");
    rd_seq(DEV0, 8'd16, 1, 8'h88, 8'h00, 8'h00, "R11 unguarded");
  endtask

  task automatic t_wp_full();
    wr_seq(DEV1, 8'd2, 1, 8'h33, 8'h00, 8'h00, "R11 write ack");
    wr_seq(DEV1, 8'd20, 1, 8'h66, 8'h00, 8'h00, "R11 write ack");
    wp1 = 1'b1;
    wr_seq(DEV1, 8'd2, 1, 8'h44, 8'h00, 8'h00, "R10 guarded ack");
    wr_seq(DEV1, 8'd20, 1, 8'h55, 8'h00, 8'h00, "R10 guarded ack");
    rd_seq(DEV1, 8'd2, 1, 8'h33, 8'h00, 8'h00, "R10 lower kept");
    rd_seq(DEV1, 8'd20, 1, 8'h66, 8'h00, 8'h00, "R10 upper kept");
    wp1 = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_read();
    t_wrap();
    t_mismatch();
    t_nack_release();
    t_after_stop();
    t_wp_half();
    t_wp_full();
    finish_up();
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end
endmodule